// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block sits in the address stage of a load/store pipeline. For each access it forms the effective address from a base operand and an offset. The offset is a second register, a signed 16-bit displacement, or a signed 14-bit displacement scaled by four. When a non-update access names register index zero as its base, the base is the constant zero and the base operand value is ignored. Update forms instead always add to the base operand and ask for the resulting address to be written back into the base register.

The unit screens each access for illegal register combinations. It puts the store data into memory lane order, and it drives a byte-reverse select from the access size and a little-endian mode bit. It keeps the context of the one access in flight. When the memory system reports completion, it issues the base-update write and the load-target write, with load data put back into register order. If the completion carries a fault, it issues neither write. The completion for an access must arrive before the next access is presented, or in the same cycle as it.

Top module: `ldst_ea_unit`

## Requirements
- R1: Indexed form (form code 0) gives address = base + second operand. With the base index at 0 and no update, the address is the second operand alone, whatever the base operand value.
- R2: Displacement form (form code 1) gives address = base + the 16-bit immediate sign-extended. With the base index at 0 and no update, it gives the sign-extended immediate alone.
- R3: Scaled form (form code 2) sign-extends immediate bits [13:0], multiplies the result by 4 and adds the base. With the base index at 0 and no update, the base is zero. Immediate bits [15:14] have no effect on the address.
- R4: An access is illegal in any of these cases: form code 3; update with base index 0; update load whose base index equals its target index. An illegal access sets out_illegal, keeps out_mem_req low and never causes a register write, even when a completion follows.
- R5: Every output of the issue side is registered, with one cycle of latency. out_valid is high in exactly the cycle after in_valid was high. out_mem_req is low whenever out_valid is low.
- R6: Size code s (0..3) means an access of 2^s bytes. out_swap is high when the little-endian mode bit is clear and s is not 0. A 1-byte access is never reordered.
- R7: out_wdata holds the low 2^s bytes of the store data, with upper bytes zero. When out_swap is high those bytes are reversed, so that lane 0 carries the most significant byte of the sized value. Lane 0 is bits [7:0].
- R8: A fault-free completion (cmp_valid with cmp_fault low) gives results one cycle later. For an update access, wb_upd_we is high, wb_upd_idx is the base index and wb_upd_data is the address. For a load, wb_rt_we is high, wb_rt_idx is the target index, and wb_rt_data is the low 2^s bytes of cmp_rdata, put into register order by the same rule as R7 and zero-extended.
- R9: A completion with cmp_fault high produces no register write.
- R10: A completion with no access pending is ignored. Each accepted access takes exactly one completion.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Access presented this cycle |
| in_form | input | 2 | Address form: 0 indexed, 1 displacement, 2 scaled, 3 reserved |
| in_update | input | 1 | Update form: write the address back to the base register |
| in_is_load | input | 1 | 1 load, 0 store |
| in_ra_idx | input | IDX_W | Base register index |
| in_rt_idx | input | IDX_W | Load target register index |
| in_ra_val | input | 64 | Base operand value |
| in_rb_val | input | 64 | Second operand value (indexed form) |
| in_imm | input | 16 | Immediate field |
| in_le | input | 1 | Little-endian mode bit |
| in_size | input | 2 | Size code, 2^code bytes |
| in_wdata | input | 64 | Store data in register order |
| cmp_valid | input | 1 | Memory completion |
| cmp_fault | input | 1 | Completion carries a fault |
| cmp_rdata | input | 64 | Load data in lane order |
| out_valid | output | 1 | Issue result valid |
| out_illegal | output | 1 | Access was illegal |
| out_mem_req | output | 1 | Memory request |
| out_wr | output | 1 | Request is a store |
| out_addr | output | 64 | Effective address |
| out_size | output | 2 | Size code of the request |
| out_swap | output | 1 | Byte-reverse select |
| out_wdata | output | 64 | Store data in lane order |
| wb_upd_we | output | 1 | Base register update write |
| wb_upd_idx | output | IDX_W | Base register index to write |
| wb_upd_data | output | 64 | Address written to the base register |
| wb_rt_we | output | 1 | Load target write |
| wb_rt_idx | output | IDX_W | Load target index |
| wb_rt_data | output | 64 | Load data in register order |

## Verification
A wrong adder input or a missing zero substitution shows as a wrong out_addr one cycle after the access. A fault in the illegality decode shows in that same cycle as a raised out_mem_req with out_illegal also high, or as a missing request. Corrupted pending context stays hidden until the completion. It then shows one cycle after cmp_valid, as a write to the wrong index, with the wrong data, or despite a fault, or as a write from a completion that had nothing pending.

// File: rtl/ldst_ea_pkg.sv
package ldst_ea_pkg;
  localparam int XLEN     = 64;
  localparam int BYTES    = XLEN / 8;
  localparam int DISP_W   = 16;
  localparam int SCALED_W = 14;
  localparam int SCALE_SH = 2;

  typedef enum logic [1:0] {
    FORM_IDX    = 2'd0,
    FORM_DISP   = 2'd1,
    FORM_SCALED = 2'd2,
    FORM_RSVD   = 2'd3
  } ea_form_e;

  // signed 16-bit displacement to full width
  function automatic logic [XLEN-1:0] sext_disp(input logic [DISP_W-1:0] imm);
    return {{(XLEN-DISP_W){imm[DISP_W-1]}}, imm};
  endfunction

  // signed 14-bit field, sign-extended then scaled
  function automatic logic [XLEN-1:0] sext_scaled(input logic [DISP_W-1:0] imm);
    logic [XLEN-1:0] v;
    v = {{(XLEN-SCALED_W){imm[SCALED_W-1]}}, imm[SCALED_W-1:0]};
    return v << SCALE_SH;
  endfunction

  function automatic logic [XLEN-1:0] calc_ea(input ea_form_e form,
                                              input logic upd,
                                              input logic base_zero,
                                              input logic [XLEN-1:0] ra,
                                              input logic [XLEN-1:0] rb,
                                              input logic [DISP_W-1:0] imm);
    logic [XLEN-1:0] base, off;
    base = (base_zero && !upd) ? '0 : ra;
    case (form)
      FORM_IDX:    off = rb;
      FORM_DISP:   off = sext_disp(imm);
      FORM_SCALED: off = sext_scaled(imm);
      default:     off = '0;
    endcase
    return base + off;
  endfunction

  // keep the low 2^size bytes, reversing them when swap is set
  function automatic logic [XLEN-1:0] lane_order(input logic [XLEN-1:0] d,
                                                 input logic [1:0] size,
                                                 input logic swap);
    logic [XLEN-1:0] r;
    int n;
    n = 1 << size;
    r = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (i < n) r[i*8 +: 8] = swap ? d[(n-1-i)*8 +: 8] : d[i*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/ldst_ea_issue.sv
module ldst_ea_issue
  import ldst_ea_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_form,
  input  logic              in_update,
  input  logic              in_is_load,
  input  logic [IDX_W-1:0]  in_ra_idx,
  input  logic [IDX_W-1:0]  in_rt_idx,
  input  logic [XLEN-1:0]   in_ra_val,
  input  logic [XLEN-1:0]   in_rb_val,
  input  logic [DISP_W-1:0] in_imm,
  input  logic              in_le,
  input  logic [1:0]        in_size,
  input  logic [XLEN-1:0]   in_wdata,
  output logic              acc_go,
  output logic [XLEN-1:0]   acc_ea,
  output logic              acc_swap,
  output logic              out_valid,
  output logic              out_illegal,
  output logic              out_mem_req,
  output logic              out_wr,
  output logic [XLEN-1:0]   out_addr,
  output logic [1:0]        out_size,
  output logic              out_swap,
  output logic [XLEN-1:0]   out_wdata
);
  ea_form_e form;
  logic     base_zero, bad_form;

  always_comb begin
    form      = ea_form_e'(in_form);
    base_zero = (in_ra_idx == '0);
    bad_form  = (form == FORM_RSVD)
             || (in_update && base_zero)
             || (in_update && in_is_load && (in_ra_idx == in_rt_idx));
    acc_ea    = calc_ea(form, in_update, base_zero, in_ra_val, in_rb_val, in_imm);
    acc_swap  = !in_le && (in_size != 2'd0);
    acc_go    = in_valid && !bad_form;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_mem_req <= 1'b0;
      out_wr      <= 1'b0;
      out_addr    <= '0;
      out_size    <= '0;
      out_swap    <= 1'b0;
      out_wdata   <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && bad_form;
      out_mem_req <= acc_go;
      out_wr      <= acc_go && !in_is_load;
      out_addr    <= in_valid ? acc_ea : '0;
      out_size    <= in_valid ? in_size : 2'd0;
      out_swap    <= in_valid && acc_swap;
      out_wdata   <= (acc_go && !in_is_load) ? lane_order(in_wdata, in_size, acc_swap) : '0;
    end
  end
endmodule

// File: rtl/ldst_ea_complete.sv
module ldst_ea_complete
  import ldst_ea_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_go,
  input  logic [XLEN-1:0]  acc_ea,
  input  logic             acc_swap,
  input  logic             in_update,
  input  logic             in_is_load,
  input  logic [IDX_W-1:0] in_ra_idx,
  input  logic [IDX_W-1:0] in_rt_idx,
  input  logic [1:0]       in_size,
  input  logic             cmp_valid,
  input  logic             cmp_fault,
  input  logic [XLEN-1:0]  cmp_rdata,
  output logic             cmp_hit,
  output logic             wb_upd_we,
  output logic [IDX_W-1:0] wb_upd_idx,
  output logic [XLEN-1:0]  wb_upd_data,
  output logic             wb_rt_we,
  output logic [IDX_W-1:0] wb_rt_idx,
  output logic [XLEN-1:0]  wb_rt_data
);
  logic             pend_v, pend_load, pend_upd, pend_swap;
  logic [IDX_W-1:0] pend_ra, pend_rt;
  logic [XLEN-1:0]  pend_addr;
  logic [1:0]       pend_size;
  logic             commit;

  assign cmp_hit = cmp_valid && pend_v;
  assign commit  = cmp_hit && !cmp_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_load <= 1'b0;
      pend_upd  <= 1'b0;
      pend_swap <= 1'b0;
      pend_ra   <= '0;
      pend_rt   <= '0;
      pend_addr <= '0;
      pend_size <= '0;
    end else begin
      if (acc_go) begin
        pend_v    <= 1'b1;
        pend_load <= in_is_load;
        pend_upd  <= in_update;
        pend_swap <= acc_swap;
        pend_ra   <= in_ra_idx;
        pend_rt   <= in_rt_idx;
        pend_addr <= acc_ea;
        pend_size <= in_size;
      end else if (cmp_hit) begin
        pend_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_upd_we   <= 1'b0;
      wb_upd_idx  <= '0;
      wb_upd_data <= '0;
      wb_rt_we    <= 1'b0;
      wb_rt_idx   <= '0;
      wb_rt_data  <= '0;
    end else begin
      wb_upd_we   <= commit && pend_upd;
      wb_upd_idx  <= (commit && pend_upd) ? pend_ra : '0;
      wb_upd_data <= (commit && pend_upd) ? pend_addr : '0;
      wb_rt_we    <= commit && pend_load;
      wb_rt_idx   <= (commit && pend_load) ? pend_rt : '0;
      wb_rt_data  <= (commit && pend_load) ? lane_order(cmp_rdata, pend_size, pend_swap) : '0;
    end
  end
endmodule

// File: rtl/ldst_ea_unit.sv
module ldst_ea_unit
  import ldst_ea_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_form,
  input  logic              in_update,
  input  logic              in_is_load,
  input  logic [IDX_W-1:0]  in_ra_idx,
  input  logic [IDX_W-1:0]  in_rt_idx,
  input  logic [XLEN-1:0]   in_ra_val,
  input  logic [XLEN-1:0]   in_rb_val,
  input  logic [DISP_W-1:0] in_imm,
  input  logic              in_le,
  input  logic [1:0]        in_size,
  input  logic [XLEN-1:0]   in_wdata,
  input  logic              cmp_valid,
  input  logic              cmp_fault,
  input  logic [XLEN-1:0]   cmp_rdata,
  output logic              out_valid,
  output logic              out_illegal,
  output logic              out_mem_req,
  output logic              out_wr,
  output logic [XLEN-1:0]   out_addr,
  output logic [1:0]        out_size,
  output logic              out_swap,
  output logic [XLEN-1:0]   out_wdata,
  output logic              wb_upd_we,
  output logic [IDX_W-1:0]  wb_upd_idx,
  output logic [XLEN-1:0]   wb_upd_data,
  output logic              wb_rt_we,
  output logic [IDX_W-1:0]  wb_rt_idx,
  output logic [XLEN-1:0]   wb_rt_data
);
  logic            acc_go, acc_swap, cmp_hit;
  logic [XLEN-1:0] acc_ea;

  ldst_ea_issue #(.IDX_W(IDX_W)) u_issue (
    .clk, .rst_n, .in_valid, .in_form, .in_update, .in_is_load,
    .in_ra_idx, .in_rt_idx, .in_ra_val, .in_rb_val, .in_imm, .in_le,
    .in_size, .in_wdata, .acc_go, .acc_ea, .acc_swap,
    .out_valid, .out_illegal, .out_mem_req, .out_wr, .out_addr,
    .out_size, .out_swap, .out_wdata
  );

  ldst_ea_complete #(.IDX_W(IDX_W)) u_cmpl (
    .clk, .rst_n, .acc_go, .acc_ea, .acc_swap, .in_update, .in_is_load,
    .in_ra_idx, .in_rt_idx, .in_size, .cmp_valid, .cmp_fault, .cmp_rdata,
    .cmp_hit, .wb_upd_we, .wb_upd_idx, .wb_upd_data, .wb_rt_we,
    .wb_rt_idx, .wb_rt_data
  );
endmodule

// File: rtl/ldst_ea_unit_chk.sv
module ldst_ea_unit_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             cmp_valid,
  input logic             cmp_fault,
  input logic             cmp_hit,
  input logic             out_valid,
  input logic             out_illegal,
  input logic             out_mem_req,
  input logic [1:0]       out_size,
  input logic             out_swap,
  input logic             wb_upd_we,
  input logic [IDX_W-1:0] wb_upd_idx,
  input logic             wb_rt_we,
  input logic [IDX_W-1:0] wb_rt_idx
);
  // R5
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_mem_req));
  // R4
  illegal_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_valid && !out_mem_req));
  // R6
  byte_never_swapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_size == 2'd0) |-> !out_swap);
  // R9
  write_needs_clean_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_upd_we || wb_rt_we) |-> $past(cmp_valid && !cmp_fault));
  // R10
  write_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_upd_we || wb_rt_we) |-> $past(cmp_hit));
  // R4
  upd_idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_upd_we |-> (wb_upd_idx != '0));
  // R4
  dual_write_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_upd_we && wb_rt_we) |-> (wb_upd_idx != wb_rt_idx));
endmodule

bind ldst_ea_unit ldst_ea_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmp_valid(cmp_valid),
  .cmp_fault(cmp_fault), .cmp_hit(cmp_hit), .out_valid(out_valid),
  .out_illegal(out_illegal), .out_mem_req(out_mem_req), .out_size(out_size),
  .out_swap(out_swap), .wb_upd_we(wb_upd_we), .wb_upd_idx(wb_upd_idx),
  .wb_rt_we(wb_rt_we), .wb_rt_idx(wb_rt_idx)
);

// File: tb/sim_ldst_ea_unit.sv
module sim_ldst_ea_unit;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_update = 0, in_is_load = 0, in_le = 0;
  logic [1:0] in_form = 0, in_size = 0;
  logic [IDX_W-1:0] in_ra_idx = 0, in_rt_idx = 0;
  logic [63:0] in_ra_val = 0, in_rb_val = 0, in_wdata = 0, cmp_rdata = 0;
  logic [15:0] in_imm = 0;
  logic cmp_valid = 0, cmp_fault = 0;
  logic out_valid, out_illegal, out_mem_req, out_wr, out_swap;
  logic [63:0] out_addr, out_wdata, wb_upd_data, wb_rt_data;
  logic [1:0] out_size;
  logic wb_upd_we, wb_rt_we;
  logic [IDX_W-1:0] wb_upd_idx, wb_rt_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_ea_unit #(.IDX_W(IDX_W)) u0 (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference: reverse or keep the low 2^s bytes, built by shifts
  function automatic logic [63:0] ref_order(logic [63:0] d, int s, bit rev);
    logic [63:0] r = 0;
    int n = 1 << s;
    for (int i = 0; i < n; i++) begin
      logic [63:0] b;
      b = rev ? ((d >> (8*(n-1-i))) & 64'hFF) : ((d >> (8*i)) & 64'hFF);
      r = r | (b << (8*i));
    end
    return r;
  endfunction

  task automatic issue(input logic [1:0] f, input bit upd, input bit ld,
                       input int ra, input int rt, input logic [63:0] rav,
                       input logic [63:0] rbv, input logic [15:0] imm,
                       input bit le, input logic [1:0] sz, input logic [63:0] wd);
    @(negedge clk);
    in_valid = 1; in_form = f; in_update = upd; in_is_load = ld;
    in_ra_idx = IDX_W'(ra); in_rt_idx = IDX_W'(rt); in_ra_val = rav;
    in_rb_val = rbv; in_imm = imm; in_le = le; in_size = sz; in_wdata = wd;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic complete(input bit flt, input logic [63:0] rd);
    cmp_valid = 1; cmp_fault = flt; cmp_rdata = rd;
    @(negedge clk);
    cmp_valid = 0; cmp_fault = 0;
  endtask

  task automatic t_reset;
    chk("R11 out_valid", 64'(out_valid), 0);
    chk("R11 out_addr", out_addr, 0);
    chk("R11 out_mem_req", 64'(out_mem_req), 0);
    chk("R11 wb_upd_we", 64'(wb_upd_we), 0);
    chk("R11 wb_rt_we", 64'(wb_rt_we), 0);
  endtask

  task automatic t_indexed;
    issue(2'd0, 0, 1, 4, 7, 64'h1000_0000_0000_0010, 64'h20, 0, 1, 2'd3, 0);
    chk("R1 indexed addr", out_addr, 64'h1000_0000_0000_0030);
    chk("R5 out_valid", 64'(out_valid), 1);
    chk("R1 indexed req", 64'(out_mem_req), 1);
    complete(0, 64'h0);
    issue(2'd0, 0, 1, 0, 7, 64'hDEAD_BEEF_0000_0000, 64'h5550, 0, 1, 2'd3, 0);
    chk("R1 base zero addr", out_addr, 64'h5550);
    complete(0, 64'h0);
    chk("R5 idle out_valid", 64'(out_valid), 0);
  endtask

  task automatic t_disp;
    issue(2'd1, 0, 0, 3, 0, 64'h100, 0, 16'hFFF0, 1, 2'd0, 64'hAB);
    chk("R2 disp negative", out_addr, 64'h0F0);
    chk("R2 store wr", 64'(out_wr), 1);
    complete(0, 0);
    issue(2'd1, 0, 0, 0, 0, 64'h9999, 0, 16'h8000, 1, 2'd0, 64'hAB);
    chk("R2 base zero", out_addr, 64'hFFFF_FFFF_FFFF_8000);
    complete(0, 0);
  endtask

  task automatic t_scaled;
    longint v = longint'(14'h2001) - 16384;
    issue(2'd2, 0, 1, 6, 9, 64'h10000, 0, 16'h2001, 1, 2'd3, 0);
    chk("R3 scaled negative", out_addr, 64'(64'h10000 + v * 4));
    complete(0, 0);
    issue(2'd2, 0, 1, 6, 9, 64'h10000, 0, 16'hE001, 1, 2'd3, 0);
    chk("R3 upper imm bits ignored", out_addr, 64'(64'h10000 + v * 4));
    complete(0, 0);
    issue(2'd2, 0, 1, 0, 9, 64'h7777, 0, 16'h0005, 1, 2'd3, 0);
    chk("R3 base zero", out_addr, 64'h14);
    complete(0, 0);
  endtask

  task automatic t_illegal;
    issue(2'd3, 0, 1, 2, 3, 0, 0, 0, 1, 2'd3, 0);
    chk("R4 rsvd form illegal", 64'(out_illegal), 1);
    chk("R4 rsvd form no req", 64'(out_mem_req), 0);
    complete(0, 64'h55);
    chk("R4 rsvd no write", 64'(wb_rt_we | wb_upd_we), 0);
    issue(2'd1, 1, 0, 0, 3, 0, 0, 16'h10, 1, 2'd3, 0);
    chk("R4 update base zero", 64'(out_illegal), 1);
    complete(0, 0);
    chk("R4 update base zero no write", 64'(wb_rt_we | wb_upd_we), 0);
    issue(2'd0, 1, 1, 8, 8, 64'h40, 64'h4, 0, 1, 2'd3, 0);
    chk("R4 update load ra==rt", 64'(out_illegal), 1);
    chk("R4 update load ra==rt no req", 64'(out_mem_req), 0);
    complete(0, 0);
    chk("R4 ra==rt no write", 64'(wb_rt_we | wb_upd_we), 0);
    issue(2'd1, 1, 0, 8, 8, 64'h40, 0, 16'h4, 1, 2'd3, 64'h1);
    chk("R4 update store ra==rt legal", 64'(out_illegal), 0);
    chk("R4 update store req", 64'(out_mem_req), 1);
    complete(0, 0);
    chk("R8 store update we", 64'(wb_upd_we), 1);
    chk("R8 store update data", wb_upd_data, 64'h44);
    chk("R8 store no rt write", 64'(wb_rt_we), 0);
  endtask

  task automatic t_swap;
    logic [63:0] d = 64'h0102_0304_0506_0708;
    for (int s = 0; s < 4; s++) begin
      for (int le = 0; le < 2; le++) begin
        bit rev = (le == 0) && (s != 0);
        issue(2'd1, 0, 0, 1, 0, 64'h200, 0, 0, bit'(le), 2'(s), d);
        chk($sformatf("R6 swap s=%0d le=%0d", s, le), 64'(out_swap), 64'(rev));
        chk($sformatf("R7 wdata s=%0d le=%0d", s, le), out_wdata, ref_order(d, s, rev));
        chk("R6 size out", 64'(out_size), 64'(s));
        complete(0, 0);
      end
    end
  endtask

  task automatic t_update_load;
    issue(2'd1, 1, 1, 5, 12, 64'h8000, 0, 16'h0008, 0, 2'd2, 0);
    chk("R8 addr", out_addr, 64'h8008);
    complete(0, 64'hFFFF_FFFF_1122_3344);
    chk("R8 upd we", 64'(wb_upd_we), 1);
    chk("R8 upd idx", 64'(wb_upd_idx), 5);
    chk("R8 upd data", wb_upd_data, 64'h8008);
    chk("R8 rt we", 64'(wb_rt_we), 1);
    chk("R8 rt idx", 64'(wb_rt_idx), 12);
    chk("R8 rt data big-endian", wb_rt_data, 64'h4433_2211);
    issue(2'd0, 0, 1, 2, 13, 64'h10, 64'h2, 0, 1, 2'd1, 0);
    complete(0, 64'hAAAA_BBBB_CCCC_DDEE);
    chk("R8 rt data little-endian half", wb_rt_data, 64'hDDEE);
    chk("R8 no upd when not update", 64'(wb_upd_we), 0);
  endtask

  task automatic t_fault;
    issue(2'd1, 1, 1, 5, 12, 64'h8000, 0, 16'h0008, 1, 2'd3, 0);
    complete(1, 64'h1234);
    chk("R9 fault no upd", 64'(wb_upd_we), 0);
    chk("R9 fault no rt", 64'(wb_rt_we), 0);
  endtask

  task automatic t_stray;
    issue(2'd0, 0, 1, 3, 4, 64'h1, 64'h1, 0, 1, 2'd3, 0);
    complete(0, 64'h77);
    chk("R10 first completion writes", 64'(wb_rt_we), 1);
    complete(0, 64'h88);
    chk("R10 second completion ignored", 64'(wb_rt_we), 0);
    complete(0, 64'h99);
    chk("R10 stray completion ignored", 64'(wb_rt_we | wb_upd_we), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_indexed();
    t_disp();
    t_scaled();
    t_illegal();
    t_swap();
    t_update_load();
    t_fault();
    t_stray();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule